// File: doc/BRIEF.md
# Translation Buffer Entry Maintenance Port

This block holds the software-visible contents of a 64-entry address translation buffer and is the port through which management commands write, read back and look up those entries. Each entry is reached as three 32-bit words selected by a small word number. Word 0 carries the virtual page number, page-size code, address-space bit and valid bit. Word 1 carries the physical page number. Word 2 carries an attribute byte and six access-permission bits, split into user and supervisor sets.

Besides the entry contents, the block keeps the current process-ID register. A word-0 write stamps the current ID into the entry, and a word-0 read copies the entry's ID back into the register. Whenever a write could leave previously cached translations stale, the block emits a one-cycle flush request. A search command scans all entries for one that maps a given address under a given address space and process ID, and returns its index. A recording variant of the search also produces a 4-bit condition field.

Each accepted command produces a registered response one clock later. The privilege check of the issuing instruction and the translation datapath that uses the entries live elsewhere.

Top module: `tlbm_port`

## Requirements
- R1: After synchronous reset every entry reads back as all-zero words (invalid, size code 0), the process-ID register is 0, and `rsp_valid`, `flush_req` and `cr0_valid` are low.
- R2: A word-0 write (op 0, word 0) stores the page number from data bits 31:10, the size code from bits 7:4, the address-space bit from bit 8 and the valid bit from bit 9. It also records the current process-ID register value in the entry. A word-0 read (op 1, word 0) returns those fields in the same bit positions, with bits 3:0 reading zero.
- R3: A word-0 write pulses `flush_req` when the entry was valid and at least one of these holds: the page number differs, the new size code is larger than the stored one, or the written valid bit is 0. Otherwise it does not flush.
- R4: A word-1 write stores the data ANDed with 0xFFFFFC0F, and a word-1 read returns that stored value. The write pulses `flush_req` only when the entry was valid and the masked value differs from the stored one.
- R5: A word-2 write stores the attribute byte from bits 15:8 and the permissions from bits 5:0. The permission bits, from bit 0 up, are user read, user write, user execute, supervisor read, supervisor write and supervisor execute. A word-2 read returns the same layout with all other bits zero. Word-1 and word-2 writes never change any entry's valid bit, and a word-2 write never flushes.
- R6: A word-0 read loads the entry's recorded process ID into the process-ID register. A stored size code above 9 reads back as 1.
- R7: A read or write with word selector 3 is rejected. It returns `rsp_bad`=1 and `rsp_data`=0, changes no entry and does not flush.
- R8: Only the low 6 bits of `cmd_index` select the entry, and the upper bits are ignored.
- R9: A search (op 2 or 3) returns, zero-extended, the lowest index whose entry matches, or 0xFFFFFFFF when none matches. An entry matches when all of the following hold: it is valid; its address-space bit equals `srch_as`; its recorded ID is 0 or equals `srch_pid`; and its page number equals `cmd_data[31:10]` outside the low 2*k bits, where k is the size code (codes above 9 count as 1).
- R10: The recording search (op 3) raises `cr0_valid` with `cr0` = {2'b00, hit, `so_bit`}. Ops 0 to 2 leave `cr0_valid` low and `cr0` zero.
- R11: The response to a command and any flush it causes appear in the cycle right after the command, and each lasts one cycle.
- R12: `pid_load` writes `pid_load_val` into the process-ID register, unless a word-0 read is accepted in the same cycle, in which case the read's value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 write, 1 read, 2 search, 3 recording search |
| cmd_word | input | 2 | Entry word selector (3 is invalid) |
| cmd_index | input | 32 | Entry index operand (low 6 bits used) |
| cmd_data | input | 32 | Write data, or search address |
| srch_as | input | 1 | Address space for search |
| srch_pid | input | 8 | Process ID for search |
| so_bit | input | 1 | Summary-overflow bit copied into the condition field |
| pid_load | input | 1 | Load strobe for the process-ID register |
| pid_load_val | input | 8 | Value for the process-ID register |
| rsp_valid | output | 1 | Response present |
| rsp_bad | output | 1 | Command rejected for an invalid word selector |
| rsp_data | output | 32 | Read word or search result |
| cr0_valid | output | 1 | Condition field present |
| cr0 | output | 4 | Condition field of a recording search |
| flush_req | output | 1 | One-cycle request to drop cached translations |
| pid_q | output | 8 | Current process-ID register |

## Verification
Entry state is never visible directly, so a corrupted field only shows up when a later command reads that entry, hits it in a search, or compares against it for a flush decision. Such an error can stay hidden for many cycles. The bench therefore reads back and searches entries right after writing them, and reuses stored page numbers as search keys so hits are frequent. A wrong flush decision or process-ID transfer shows up on `flush_req` or `pid_q` exactly one cycle after the command, and every command is checked at that cycle.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;
  localparam int EPN_W  = 22;
  localparam int SZ_W   = 4;
  localparam int ATTR_W = 8;
  localparam int PERM_W = 6;
  localparam logic [SZ_W-1:0] SZ_MAX   = 4'd9;
  localparam logic [31:0]     RPN_MASK = 32'hFFFF_FC0F;

  typedef enum logic [1:0] {
    OP_WRITE      = 2'd0,
    OP_READ       = 2'd1,
    OP_SEARCH     = 2'd2,
    OP_SEARCH_REC = 2'd3
  } op_e;

  typedef struct packed {
    logic [EPN_W-1:0]  epn;
    logic [SZ_W-1:0]   sz;
    logic              as_bit;
    logic              vld;
    logic [31:0]       rpn;
    logic [ATTR_W-1:0] attr;
    logic [PERM_W-1:0] perm;
  } tlb_ent_t;

  // Out-of-range size codes behave as code 1
  function automatic logic [SZ_W-1:0] sz_eff(input logic [SZ_W-1:0] c);
    return (c > SZ_MAX) ? 4'd1 : c;
  endfunction

  // Page-number bits that take part in a compare for a given size code
  function automatic logic [EPN_W-1:0] epn_mask(input logic [SZ_W-1:0] c);
    logic [SZ_W-1:0] e;
    e = sz_eff(c);
    return {EPN_W{1'b1}} << (2 * e);
  endfunction
endpackage

// File: rtl/tlbm_store.sv
module tlbm_store
  import tlbm_pkg::*;
#(
  parameter int N     = 64,
  parameter int PID_W = 8,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [1:0]       wr_word,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_data,
  input  logic [PID_W-1:0] cur_pid,
  output tlb_ent_t         ent     [N],
  output logic [PID_W-1:0] ent_pid [N],
  output logic             flush_hit
);
  tlb_ent_t         old;
  logic [EPN_W-1:0] new_epn;
  logic [SZ_W-1:0]  new_sz;
  logic             new_vld;
  logic [31:0]      new_rpn;
  logic [N-1:0]     vld_vec;

  assign old     = ent[wr_idx];
  assign new_epn = wr_data[31:10];
  assign new_sz  = wr_data[7:4];
  assign new_vld = wr_data[9];
  assign new_rpn = wr_data & RPN_MASK;

  // Stale-translation detection, computed from the entry as it was
  always_comb begin
    flush_hit = 1'b0;
    if (we && old.vld) begin
      case (wr_word)
        2'd0:    flush_hit = (new_epn != old.epn) || (new_sz > old.sz) || !new_vld;
        2'd1:    flush_hit = (new_rpn != old.rpn);
        default: flush_hit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        ent[i]     <= '0;
        ent_pid[i] <= '0;
      end
    end else if (we) begin
      case (wr_word)
        2'd0: begin
          ent[wr_idx].epn    <= new_epn;
          ent[wr_idx].sz     <= new_sz;
          ent[wr_idx].as_bit <= wr_data[8];
          ent[wr_idx].vld    <= new_vld;
          ent_pid[wr_idx]    <= cur_pid;
        end
        2'd1: ent[wr_idx].rpn <= new_rpn;
        2'd2: begin
          ent[wr_idx].attr <= wr_data[15:8];
          ent[wr_idx].perm <= wr_data[5:0];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) vld_vec[i] = ent[i].vld;
  end

  // R5: only word-0 writes may alter a valid bit
  p_vld_kept_r5: assert property (@(posedge clk) disable iff (rst)
    (we && wr_word != 2'd0) |=> $stable(vld_vec));
endmodule

// File: rtl/tlbm_search.sv
module tlbm_search
  import tlbm_pkg::*;
#(
  parameter int N     = 64,
  parameter int PID_W = 8,
  parameter int IDX_W = 6
) (
  input  tlb_ent_t         ent     [N],
  input  logic [PID_W-1:0] ent_pid [N],
  input  logic [31:0]      key,
  input  logic             s_as,
  input  logic [PID_W-1:0] s_pid,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx
);
  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = ent[g].vld && (ent[g].as_bit == s_as) &&
                      ((ent_pid[g] == '0) || (ent_pid[g] == s_pid)) &&
                      (((ent[g].epn ^ key[31:10]) & epn_mask(ent[g].sz)) == '0);
  end

  // Lowest index wins: scan downwards, last assignment sticks
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  // R9: a reported hit always points at a matching entry
  always_comb begin
    if (hit) p_hit_match_r9: assert (match[hit_idx]);
  end
endmodule

// File: rtl/tlbm_port.sv
module tlbm_port
  import tlbm_pkg::*;
#(
  parameter int N_ENT = 64,
  parameter int PID_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [1:0]       cmd_word,
  input  logic [31:0]      cmd_index,
  input  logic [31:0]      cmd_data,
  input  logic             srch_as,
  input  logic [PID_W-1:0] srch_pid,
  input  logic             so_bit,
  input  logic             pid_load,
  input  logic [PID_W-1:0] pid_load_val,
  output logic             rsp_valid,
  output logic             rsp_bad,
  output logic [31:0]      rsp_data,
  output logic             cr0_valid,
  output logic [3:0]       cr0,
  output logic             flush_req,
  output logic [PID_W-1:0] pid_q
);
  localparam int IDX_W = $clog2(N_ENT);

  tlb_ent_t         ent     [N_ENT];
  logic [PID_W-1:0] ent_pid [N_ENT];
  logic [IDX_W-1:0] idx;
  logic             sel_ok, is_wr, is_rd, is_srch, do_wr, rd_w0;
  logic             flush_hit, s_hit;
  logic [IDX_W-1:0] s_idx;
  logic [31:0]      rd_word;
  tlb_ent_t         e;

  assign idx     = cmd_index[IDX_W-1:0];
  assign sel_ok  = (cmd_word != 2'd3);
  assign is_wr   = cmd_valid && (cmd_op == OP_WRITE);
  assign is_rd   = cmd_valid && (cmd_op == OP_READ);
  assign is_srch = cmd_valid && (cmd_op == OP_SEARCH || cmd_op == OP_SEARCH_REC);
  assign do_wr   = is_wr && sel_ok;
  assign rd_w0   = is_rd && (cmd_word == 2'd0);

  tlbm_store #(.N(N_ENT), .PID_W(PID_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst), .we(do_wr), .wr_word(cmd_word), .wr_idx(idx),
    .wr_data(cmd_data), .cur_pid(pid_q), .ent(ent), .ent_pid(ent_pid),
    .flush_hit(flush_hit)
  );

  tlbm_search #(.N(N_ENT), .PID_W(PID_W), .IDX_W(IDX_W)) u_search (
    .ent(ent), .ent_pid(ent_pid), .key(cmd_data), .s_as(srch_as),
    .s_pid(srch_pid), .hit(s_hit), .hit_idx(s_idx)
  );

  assign e = ent[idx];

  always_comb begin
    case (cmd_word)
      2'd0:    rd_word = {e.epn, e.vld, e.as_bit, sz_eff(e.sz), 4'b0000};
      2'd1:    rd_word = e.rpn;
      2'd2:    rd_word = {16'h0000, e.attr, 2'b00, e.perm};
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_bad   <= 1'b0;
      rsp_data  <= '0;
      cr0_valid <= 1'b0;
      cr0       <= '0;
      flush_req <= 1'b0;
      pid_q     <= '0;
    end else begin
      rsp_valid <= cmd_valid;
      rsp_bad   <= (is_wr || is_rd) && !sel_ok;
      flush_req <= flush_hit;
      if (is_rd && sel_ok)  rsp_data <= rd_word;
      else if (is_srch)     rsp_data <= s_hit ? 32'(s_idx) : '1;
      else                  rsp_data <= '0;
      cr0_valid <= cmd_valid && (cmd_op == OP_SEARCH_REC);
      cr0       <= (cmd_valid && cmd_op == OP_SEARCH_REC) ? {2'b00, s_hit, so_bit} : 4'h0;
      if (rd_w0)         pid_q <= ent_pid[idx];
      else if (pid_load) pid_q <= pid_load_val;
    end
  end

  // R3/R4: flushes are only ever caused by a write command
  p_flush_src_r3: assert property (@(posedge clk) disable iff (rst)
    flush_req |-> $past(cmd_valid && cmd_op == OP_WRITE));
  // R11: responses answer the command of the previous cycle
  p_rsp_lat_r11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(cmd_valid));
  // R7: a rejected command neither flushes nor returns data
  p_bad_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_bad |-> (!flush_req && rsp_data == '0));
  // R10: the condition field rides along with a response
  p_cr0_pair_r10: assert property (@(posedge clk) disable iff (rst)
    cr0_valid |-> (rsp_valid && !rsp_bad));
  // R9: a recorded miss reports the all-ones index
  p_miss_ones_r9: assert property (@(posedge clk) disable iff (rst)
    (cr0_valid && !cr0[1]) |-> (rsp_data == 32'hFFFF_FFFF));
endmodule

// File: tb/tlbm_port_tb.sv
`timescale 1ns/1ps
module tlbm_port_tb;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0, cmd_word = '0;
  logic [31:0] cmd_index = '0, cmd_data = '0;
  logic        srch_as = 1'b0;
  logic [7:0]  srch_pid = '0;
  logic        so_bit = 1'b0;
  logic        pid_load = 1'b0;
  logic [7:0]  pid_load_val = '0;
  logic        rsp_valid, rsp_bad, cr0_valid, flush_req;
  logic [31:0] rsp_data;
  logic [3:0]  cr0;
  logic [7:0]  pid_q;

  int n_tot = 0;
  int n_bad = 0;

  // Reference model
  logic [21:0] m_epn [N];
  logic [3:0]  m_sz  [N];
  logic        m_as  [N];
  logic        m_v   [N];
  logic [31:0] m_rpn [N];
  logic [7:0]  m_attr[N];
  logic [5:0]  m_perm[N];
  logic [7:0]  m_epid[N];
  logic [7:0]  m_pid;

  always #2 clk = ~clk;

  tlbm_port u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_word(cmd_word),
    .cmd_index(cmd_index), .cmd_data(cmd_data), .srch_as(srch_as), .srch_pid(srch_pid),
    .so_bit(so_bit), .pid_load(pid_load), .pid_load_val(pid_load_val),
    .rsp_valid(rsp_valid), .rsp_bad(rsp_bad), .rsp_data(rsp_data), .cr0_valid(cr0_valid),
    .cr0(cr0), .flush_req(flush_req), .pid_q(pid_q)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tot++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [3:0] eff(input logic [3:0] c);
    return (c > 4'd9) ? 4'd1 : c;
  endfunction

  function automatic logic [32:0] model_search(input logic [31:0] key, input logic as_i,
                                               input logic [7:0] sp);
    for (int i = 0; i < N; i++) begin
      logic [21:0] msk;
      msk = ~((22'd1 << (2 * eff(m_sz[i]))) - 22'd1);
      if (m_v[i] && m_as[i] == as_i && (m_epid[i] == 8'd0 || m_epid[i] == sp) &&
          ((m_epn[i] & msk) == (key[31:10] & msk)))
        return {1'b1, 32'(i)};
    end
    return {1'b0, 32'hFFFF_FFFF};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_epn[i] = '0; m_sz[i] = '0; m_as[i] = 1'b0; m_v[i] = 1'b0;
      m_rpn[i] = '0; m_attr[i] = '0; m_perm[i] = '0; m_epid[i] = '0;
    end
    m_pid = '0;
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [1:0] w, input logic [31:0] ix,
                         input logic [31:0] dat, input logic as_i, input logic [7:0] sp,
                         input logic so_i, input string tag);
    int          k;
    logic        e_bad, e_flush, e_cv;
    logic [31:0] e_data;
    logic [3:0]  e_cr0;
    logic [7:0]  e_pid;
    logic [32:0] sr;
    k = int'(ix[5:0]);
    e_bad = (op <= 2'd1) && (w == 2'd3);
    e_flush = 1'b0; e_data = '0; e_cv = (op == 2'd3); e_cr0 = '0; e_pid = m_pid;
    if (op == 2'd0 && !e_bad) begin
      case (w)
        2'd0: begin
          e_flush = m_v[k] && (dat[31:10] != m_epn[k] || dat[7:4] > m_sz[k] || !dat[9]);
          m_epn[k] = dat[31:10]; m_sz[k] = dat[7:4]; m_as[k] = dat[8]; m_v[k] = dat[9];
          m_epid[k] = m_pid;
        end
        2'd1: begin
          e_flush = m_v[k] && ((dat & 32'hFFFF_FC0F) != m_rpn[k]);
          m_rpn[k] = dat & 32'hFFFF_FC0F;
        end
        default: begin
          m_attr[k] = dat[15:8]; m_perm[k] = dat[5:0];
        end
      endcase
    end else if (op == 2'd1 && !e_bad) begin
      case (w)
        2'd0: begin
          e_data = {m_epn[k], m_v[k], m_as[k], eff(m_sz[k]), 4'h0};
          e_pid  = m_epid[k];
        end
        2'd1:    e_data = m_rpn[k];
        default: e_data = {16'h0, m_attr[k], 2'b00, m_perm[k]};
      endcase
    end else if (op >= 2'd2) begin
      sr = model_search(dat, as_i, sp);
      e_data = sr[31:0];
      if (op == 2'd3) e_cr0 = {2'b00, sr[32], so_i};
    end
    cmd_valid = 1'b1; cmd_op = op; cmd_word = w; cmd_index = ix; cmd_data = dat;
    srch_as = as_i; srch_pid = sp; so_bit = so_i;
    @(negedge clk);
    cmd_valid = 1'b0;
    m_pid = e_pid;
    chk({tag, " R11 rsp_valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " R7 rsp_bad"}, 32'(rsp_bad), 32'(e_bad));
    chk({tag, " data"}, rsp_data, e_data);
    chk({tag, " R3 R4 flush"}, 32'(flush_req), 32'(e_flush));
    chk({tag, " R10 cr0_valid"}, 32'(cr0_valid), 32'(e_cv));
    chk({tag, " R10 cr0"}, 32'(cr0), 32'(e_cr0));
    chk({tag, " R6 pid"}, 32'(pid_q), 32'(m_pid));
  endtask

  task automatic set_pid(input logic [7:0] v);
    pid_load = 1'b1; pid_load_val = v;
    @(negedge clk);
    pid_load = 1'b0;
    m_pid = v;
    chk("R12 pid_load", 32'(pid_q), 32'(v));
    chk("R11 idle rsp", 32'(rsp_valid), 32'd0);
  endtask

  function automatic logic [31:0] w0(input logic [21:0] epn, input logic v, input logic as_i,
                                     input logic [3:0] sz);
    return {epn, v, as_i, sz, 4'h0};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_tot++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1 flush", 32'(flush_req), 32'd0);
    chk("R1 pid", 32'(pid_q), 32'd0);
    chk("R1 cr0_valid", 32'(cr0_valid), 32'd0);
    run_cmd(2'd1, 2'd0, 32'd5, '0, 1'b0, 8'd0, 1'b0, "R1 read w0");
    run_cmd(2'd1, 2'd2, 32'd63, '0, 1'b0, 8'd0, 1'b0, "R1 read w2");
    run_cmd(2'd3, 2'd0, 32'd0, 32'h1234_5678, 1'b0, 8'd0, 1'b1, "R9 miss after reset");

    // R2: word-0 write with PID capture, then readback
    set_pid(8'h5A);
    run_cmd(2'd0, 2'd0, 32'd3, w0(22'h12345, 1'b1, 1'b1, 4'd2), 1'b0, 8'd0, 1'b0, "R2 write w0");
    set_pid(8'h00);
    run_cmd(2'd1, 2'd0, 32'd3, '0, 1'b0, 8'd0, 1'b0, "R2 R6 read w0 restores pid");
    // R8: upper index bits ignored
    run_cmd(2'd1, 2'd0, 32'hFFFF_FF43, '0, 1'b0, 8'd0, 1'b0, "R8 aliased index");
    // R3 flush rules
    run_cmd(2'd0, 2'd0, 32'd3, w0(22'h12345, 1'b1, 1'b0, 4'd2), 1'b0, 8'd0, 1'b0, "R3 same epn size");
    run_cmd(2'd0, 2'd0, 32'd3, w0(22'h12345, 1'b1, 1'b0, 4'd1), 1'b0, 8'd0, 1'b0, "R3 smaller size");
    run_cmd(2'd0, 2'd0, 32'd3, w0(22'h12345, 1'b1, 1'b0, 4'd4), 1'b0, 8'd0, 1'b0, "R3 larger size");
    run_cmd(2'd0, 2'd0, 32'd3, w0(22'h12346, 1'b1, 1'b0, 4'd4), 1'b0, 8'd0, 1'b0, "R3 epn change");
    // R4 word 1
    run_cmd(2'd0, 2'd1, 32'd3, 32'hFFFF_FFFF, 1'b0, 8'd0, 1'b0, "R4 rpn first");
    run_cmd(2'd0, 2'd1, 32'd3, 32'hFFFF_FFFF, 1'b0, 8'd0, 1'b0, "R4 rpn same");
    run_cmd(2'd1, 2'd1, 32'd3, '0, 1'b0, 8'd0, 1'b0, "R4 rpn readback");
    // R5 word 2 keeps valid
    run_cmd(2'd0, 2'd2, 32'd3, 32'hFFFF_FFFF, 1'b0, 8'd0, 1'b0, "R5 write w2");
    run_cmd(2'd1, 2'd2, 32'd3, '0, 1'b0, 8'd0, 1'b0, "R5 read w2");
    run_cmd(2'd1, 2'd0, 32'd3, '0, 1'b0, 8'd0, 1'b0, "R5 valid kept");
    // R7 invalid selector, then confirm entry untouched
    run_cmd(2'd0, 2'd3, 32'd3, 32'h0, 1'b0, 8'd0, 1'b0, "R7 bad write");
    run_cmd(2'd1, 2'd3, 32'd3, 32'h0, 1'b0, 8'd0, 1'b0, "R7 bad read");
    run_cmd(2'd1, 2'd0, 32'd3, '0, 1'b0, 8'd0, 1'b0, "R7 entry unchanged");
    // R6 out-of-range size reads as 1
    run_cmd(2'd0, 2'd0, 32'd9, w0(22'h00AAA, 1'b1, 1'b0, 4'd12), 1'b0, 8'd0, 1'b0, "R6 write sz12");
    run_cmd(2'd1, 2'd0, 32'd9, '0, 1'b0, 8'd0, 1'b0, "R6 sz12 reads 1");
    // R9 priority and masking
    set_pid(8'h07);
    run_cmd(2'd0, 2'd0, 32'd20, w0(22'h3F000, 1'b1, 1'b0, 4'd3), 1'b0, 8'd0, 1'b0, "R9 setup 20");
    run_cmd(2'd0, 2'd0, 32'd7, w0(22'h3F000, 1'b1, 1'b0, 4'd3), 1'b0, 8'd0, 1'b0, "R9 setup 7");
    run_cmd(2'd3, 2'd0, 32'd0, {22'h3F03F, 10'h155}, 1'b0, 8'h07, 1'b0, "R9 lowest index hit");
    run_cmd(2'd2, 2'd0, 32'd0, {22'h3F040, 10'h0}, 1'b0, 8'h07, 1'b0, "R9 outside page");
    run_cmd(2'd3, 2'd0, 32'd0, {22'h3F000, 10'h0}, 1'b0, 8'h08, 1'b1, "R9 pid mismatch");
    run_cmd(2'd3, 2'd0, 32'd0, {22'h3F000, 10'h0}, 1'b1, 8'h07, 1'b0, "R9 as mismatch");
    // R3 clearing valid flushes
    run_cmd(2'd0, 2'd0, 32'd7, w0(22'h3F000, 1'b0, 1'b0, 4'd3), 1'b0, 8'd0, 1'b0, "R3 clear valid");
    run_cmd(2'd0, 2'd1, 32'd7, 32'h1234_5678, 1'b0, 8'd0, 1'b0, "R4 invalid no flush");
    // R12 read wins over pid_load
    pid_load = 1'b1; pid_load_val = 8'hEE;
    run_cmd(2'd1, 2'd0, 32'd20, '0, 1'b0, 8'd0, 1'b0, "R12 read beats load");
    pid_load = 1'b0;

    // Random mix
    for (int it = 0; it < 1500; it++) begin
      logic [1:0]  op, w;
      logic [31:0] ix, dat;
      int          j;
      logic        a;
      logic [7:0]  sp;
      op = 2'($urandom_range(0, 3));
      w  = 2'($urandom_range(0, 3));
      ix = $urandom();
      dat = $urandom();
      j = $urandom_range(0, N - 1);
      a = 1'($urandom_range(0, 1));
      sp = 8'($urandom_range(0, 3));
      if (op == 2'd0 && w == 2'd0) dat[21:10] = 12'h0;
      if (op >= 2'd2 && $urandom_range(0, 3) != 0) begin
        dat = {m_epn[j], 10'($urandom())};
        a = m_as[j];
        sp = ($urandom_range(0, 3) != 0) ? m_epid[j] : sp;
      end
      if ($urandom_range(0, 9) == 0) set_pid(8'($urandom_range(0, 3)));
      run_cmd(op, w, ix, dat, a, sp, 1'($urandom_range(0, 1)), "RND R2 R5 R9");
    end

    $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end
endmodule